// File: doc/BRIEF.md
# Per-Context Memory Protection Checker

This block decides whether one bus access may go ahead. It holds sixteen region descriptors that all contexts share. Each descriptor has an enable, a size-aligned base address, a power-of-two size and an access attribute. Each context also holds a sixteen-bit mask that says which descriptors govern that context. For each access the block gets the address, the direction and the id of the issuing context. One cycle later it returns either a grant or a fault, together with the index of the region that decided the outcome.

An address that no enabled region covers is open to every context. An address that is covered only by regions that do not apply to the current context is refused. Where several applicable regions overlap, the highest-numbered one decides. When an access faults, the block records the context id and the address of that access. The master context, context 0, can rewrite the descriptors and masks through a one-cycle write strobe. Writes issued on behalf of any other context are dropped.

Top module: `ctx_mem_guard`

## Requirements
- R1: After reset, all descriptors are disabled, all masks are zero, and `rsp_valid`, `rsp_grant`, `rsp_fault`, `rsp_hit`, `rsp_region`, `flt_ctx` and `flt_addr` are zero. Any access made before configuration is granted.
- R2: `rsp_valid` follows `acc_valid` by exactly one clock. While `rsp_valid` is high, exactly one of `rsp_grant` and `rsp_fault` is high. While it is low, both are low.
- R3: Region n covers an address when the address and the base agree in every bit at or above position S. S is the size field, but a size field below 6 counts as 6, so the smallest region is 64 bytes. A size field of `ADDR_W` or more covers the whole address space.
- R4: An address covered by no enabled region is granted for read and write to every context, with `rsp_hit`=0 and `rsp_region`=0.
- R5: An address covered by at least one enabled region, none of whose mask bits is set for the current context, faults. It reports `rsp_hit`=1 and `rsp_region` equal to the highest-numbered covering region.
- R6: The attribute encoding is 2'b10 read/write, 2'b01 read-only and 2'b00 no access. The reserved code 2'b11 behaves as no access. A write to a read-only region faults, and any access to a no-access region faults.
- R7: When several applicable regions cover the address, the highest-numbered one decides the outcome and is reported in `rsp_region`, with `rsp_hit`=1.
- R8: Bit n of context c's mask makes region n apply to context c. A context id with no mask register (id of `NUM_CTX` or more) has an empty mask.
- R9: A descriptor whose enable bit is 0 covers nothing.
- R10: A configuration write (`cfg_kind` 0 = descriptor `cfg_idx`, 1 = mask of context `cfg_idx`) takes effect only when `cfg_ctx` is 0. Writes with any other `cfg_ctx` leave every descriptor and mask unchanged.
- R11: On a fault, `flt_ctx` and `flt_addr` take the context id and address of the faulting access. On a grant they keep their previous values.
- R12: An access presented in the same cycle as an accepted configuration write is judged against the configuration from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctx | input | CTX_W | Context issuing the configuration write |
| cfg_kind | input | 1 | 0 = region descriptor, 1 = context mask |
| cfg_idx | input | IDX_W | Region index or context index |
| cfg_en | input | 1 | Descriptor enable |
| cfg_base | input | ADDR_W | Descriptor base address |
| cfg_lsz | input | 6 | Descriptor log2 size |
| cfg_attr | input | 2 | Descriptor attribute |
| cfg_mask | input | NUM_REGIONS | Context region mask |
| acc_valid | input | 1 | Access present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ctx | input | CTX_W | Issuing context |
| acc_addr | input | ADDR_W | Access address |
| rsp_valid | output | 1 | Verdict valid |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access refused |
| rsp_hit | output | 1 | Some enabled region covered the address |
| rsp_region | output | IDX_W | Deciding region index |
| flt_ctx | output | CTX_W | Context of the last fault |
| flt_addr | output | ADDR_W | Address of the last fault |

## Verification
A fixed region map is loaded with a catch-all region in the lower half, overlapping regions that carry opposite rules for two contexts, a nested no-access window over a read/write region, a region with a tiny size field, a region with the reserved attribute and a disabled region. Accesses then probe each of these from inside, from outside and across region edges. Because each pattern is placed where only one rule can explain the expected verdict, the probes separate priority order from first-match order, size clamping from literal sizing, and "unassigned" from "uncovered". Directed steps then cover writes from non-master contexts, a configuration write landing in the same cycle as an access, a whole-space region, and the fault record holding across a grant.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  localparam int LSZ_W = 6;

  typedef enum logic [1:0] {
    ATTR_NONE = 2'b00,
    ATTR_RO   = 2'b01,
    ATTR_RW   = 2'b10,
    ATTR_RSVD = 2'b11
  } attr_e;

  localparam logic CFG_REGION = 1'b0;
  localparam logic CFG_MASK   = 1'b1;
endpackage

// File: rtl/mpg_region_file.sv
module mpg_region_file
  import mpg_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 16,
  parameter int NUM_CTX     = 5,
  localparam int CTX_W      = $clog2(NUM_CTX),
  localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   cfg_we,
  input  logic [CTX_W-1:0]                       cfg_ctx,
  input  logic                                   cfg_kind,
  input  logic [IDX_W-1:0]                       cfg_idx,
  input  logic                                   cfg_en,
  input  logic [ADDR_W-1:0]                      cfg_base,
  input  logic [LSZ_W-1:0]                       cfg_lsz,
  input  logic [1:0]                             cfg_attr,
  input  logic [NUM_REGIONS-1:0]                 cfg_mask,
  output logic [NUM_REGIONS-1:0]                 r_en,
  output logic [NUM_REGIONS-1:0][ADDR_W-1:0]     r_base,
  output logic [NUM_REGIONS-1:0][LSZ_W-1:0]      r_lsz,
  output logic [NUM_REGIONS-1:0][1:0]            r_attr,
  output logic [NUM_CTX-1:0][NUM_REGIONS-1:0]    c_mask
);

  logic wr_ok;
  assign wr_ok = cfg_we && (cfg_ctx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      r_en   <= '0;
      r_base <= '0;
      r_lsz  <= '0;
      r_attr <= '0;
      c_mask <= '0;
    end else if (wr_ok) begin
      if (cfg_kind == CFG_REGION) begin
        r_en[cfg_idx]   <= cfg_en;
        r_base[cfg_idx] <= cfg_base;
        r_lsz[cfg_idx]  <= cfg_lsz;
        r_attr[cfg_idx] <= cfg_attr;
      end else begin
        for (int c = 0; c < NUM_CTX; c++) begin
          if (cfg_idx == IDX_W'(c)) c_mask[c] <= cfg_mask;
        end
      end
    end
  end

  // R10: configuration from a non-master context changes nothing
  assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_ctx != '0) |=> ($stable(r_en) && $stable(r_base) &&
      $stable(r_lsz) && $stable(r_attr) && $stable(c_mask)));

endmodule

// File: rtl/mpg_region_match.sv
module mpg_region_match
  import mpg_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MIN_LOG2 = 6
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] base,
  input  logic [LSZ_W-1:0]  lsz,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam logic [LSZ_W-1:0] FLOOR = LSZ_W'(MIN_LOG2);

  logic [LSZ_W-1:0]  eff;
  logic [ADDR_W-1:0] keep;

  always_comb begin
    eff = (lsz < FLOOR) ? FLOOR : lsz;
    if (int'(eff) >= ADDR_W) keep = '0;
    else                     keep = {ADDR_W{1'b1}} << eff;
    hit = en && (((addr ^ base) & keep) == '0);
  end

endmodule

// File: rtl/mpg_resolve.sv
module mpg_resolve
  import mpg_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic [NUM_REGIONS-1:0]      covered,
  input  logic [NUM_REGIONS-1:0]      applicable,
  input  logic [NUM_REGIONS-1:0][1:0] attr,
  input  logic                        is_write,
  output logic                        grant,
  output logic                        hit,
  output logic [IDX_W-1:0]            win_idx
);

  logic [IDX_W-1:0] top_cov;
  logic [IDX_W-1:0] top_app;
  attr_e            win_attr;

  always_comb begin
    top_cov = '0;
    top_app = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (covered[i])    top_cov = IDX_W'(i);
      if (applicable[i]) top_app = IDX_W'(i);
    end
    win_attr = attr_e'(attr[top_app]);

    if (covered == '0) begin
      grant   = 1'b1;
      hit     = 1'b0;
      win_idx = '0;
    end else if (applicable == '0) begin
      grant   = 1'b0;
      hit     = 1'b1;
      win_idx = top_cov;
    end else begin
      hit     = 1'b1;
      win_idx = top_app;
      grant   = (win_attr == ATTR_RW) || ((win_attr == ATTR_RO) && !is_write);
    end
  end

endmodule

// File: rtl/ctx_mem_guard.sv
module ctx_mem_guard
  import mpg_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 16,
  parameter int NUM_CTX     = 5,
  parameter int MIN_LOG2    = 6,
  localparam int CTX_W      = $clog2(NUM_CTX),
  localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [CTX_W-1:0]       cfg_ctx,
  input  logic                   cfg_kind,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  logic                   cfg_en,
  input  logic [ADDR_W-1:0]      cfg_base,
  input  logic [5:0]             cfg_lsz,
  input  logic [1:0]             cfg_attr,
  input  logic [NUM_REGIONS-1:0] cfg_mask,
  input  logic                   acc_valid,
  input  logic                   acc_write,
  input  logic [CTX_W-1:0]       acc_ctx,
  input  logic [ADDR_W-1:0]      acc_addr,
  output logic                   rsp_valid,
  output logic                   rsp_grant,
  output logic                   rsp_fault,
  output logic                   rsp_hit,
  output logic [IDX_W-1:0]       rsp_region,
  output logic [CTX_W-1:0]       flt_ctx,
  output logic [ADDR_W-1:0]      flt_addr
);

  logic [NUM_REGIONS-1:0]                 r_en;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0]     r_base;
  logic [NUM_REGIONS-1:0][LSZ_W-1:0]      r_lsz;
  logic [NUM_REGIONS-1:0][1:0]            r_attr;
  logic [NUM_CTX-1:0][NUM_REGIONS-1:0]    c_mask;

  mpg_region_file #(
    .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .NUM_CTX(NUM_CTX)
  ) u_file (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_ctx(cfg_ctx), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
    .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_lsz(cfg_lsz), .cfg_attr(cfg_attr),
    .cfg_mask(cfg_mask),
    .r_en(r_en), .r_base(r_base), .r_lsz(r_lsz), .r_attr(r_attr), .c_mask(c_mask)
  );

  logic [NUM_REGIONS-1:0] covered;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    mpg_region_match #(.ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2)) u_cmp (
      .en(r_en[g]), .base(r_base[g]), .lsz(r_lsz[g]),
      .addr(acc_addr), .hit(covered[g])
    );
  end

  logic [NUM_REGIONS-1:0] ctx_sel;
  logic [NUM_REGIONS-1:0] applicable;

  always_comb begin
    ctx_sel = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (acc_ctx == CTX_W'(c)) ctx_sel = c_mask[c];
    end
    applicable = covered & ctx_sel;
  end

  logic             v_grant;
  logic             v_hit;
  logic [IDX_W-1:0] v_idx;

  mpg_resolve #(.NUM_REGIONS(NUM_REGIONS)) u_pick (
    .covered(covered), .applicable(applicable), .attr(r_attr),
    .is_write(acc_write),
    .grant(v_grant), .hit(v_hit), .win_idx(v_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_grant  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_region <= '0;
      flt_ctx    <= '0;
      flt_addr   <= '0;
    end else begin
      rsp_valid  <= acc_valid;
      rsp_grant  <= acc_valid && v_grant;
      rsp_fault  <= acc_valid && !v_grant;
      rsp_hit    <= acc_valid && v_hit;
      rsp_region <= acc_valid ? v_idx : '0;
      if (acc_valid && !v_grant) begin
        flt_ctx  <= acc_ctx;
        flt_addr <= acc_addr;
      end
    end
  end

  // R2: one verdict per valid response
  assert_verdict_excl_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_grant ^ rsp_fault));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_grant && !rsp_fault));
  // R4: uncovered address is granted
  assert_open_space_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && covered == '0) |=> (rsp_grant && !rsp_hit));
  // R5: covered but unassigned faults
  assert_unassigned_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && covered != '0 && applicable == '0) |=> rsp_fault);
  // R7: the deciding region is one that applies
  assert_winner_applies_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && applicable != '0) |-> applicable[v_idx]);
  // R11: fault record holds across a grant
  assert_flt_hold_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_grant |-> ($stable(flt_ctx) && $stable(flt_addr)));

endmodule

// File: tb/ctx_mem_guard_tb.sv
`timescale 1ns/1ps
module ctx_mem_guard_tb_top;
  localparam int AW = 32;
  localparam int NR = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_ctx = '0;
  logic          cfg_kind = 1'b0;
  logic [3:0]    cfg_idx = '0;
  logic          cfg_en = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [5:0]    cfg_lsz = '0;
  logic [1:0]    cfg_attr = '0;
  logic [NR-1:0] cfg_mask = '0;
  logic          acc_valid = 1'b0;
  logic          acc_write = 1'b0;
  logic [2:0]    acc_ctx = '0;
  logic [AW-1:0] acc_addr = '0;
  logic          rsp_valid, rsp_grant, rsp_fault, rsp_hit;
  logic [3:0]    rsp_region;
  logic [2:0]    flt_ctx;
  logic [AW-1:0] flt_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctx_mem_guard dut_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_ctx(cfg_ctx), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
    .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_lsz(cfg_lsz), .cfg_attr(cfg_attr),
    .cfg_mask(cfg_mask),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_ctx(acc_ctx), .acc_addr(acc_addr),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
    .rsp_hit(rsp_hit), .rsp_region(rsp_region), .flt_ctx(flt_ctx), .flt_addr(flt_addr)
  );

  // vector: ctx[41:39] wr[38] addr[37:6] grant[5] hit[4] region[3:0]
  localparam int NV = 19;
  localparam logic [41:0] VEC [NV] = '{
    {3'd1, 1'b0, 32'h0010_0040, 1'b1, 1'b1, 4'd1},
    {3'd1, 1'b1, 32'h0010_0040, 1'b0, 1'b1, 4'd1},
    {3'd2, 1'b1, 32'h0020_1000, 1'b1, 1'b1, 4'd2},
    {3'd3, 1'b1, 32'h0030_0010, 1'b1, 1'b1, 4'd3},
    {3'd4, 1'b1, 32'h0030_0010, 1'b0, 1'b1, 4'd4},
    {3'd4, 1'b0, 32'h0030_0010, 1'b1, 1'b1, 4'd4},
    {3'd1, 1'b0, 32'h0030_0010, 1'b0, 1'b1, 4'd4},
    {3'd1, 1'b1, 32'h0040_003C, 1'b1, 1'b1, 4'd5},
    {3'd1, 1'b1, 32'h0040_0040, 1'b0, 1'b1, 4'd0},
    {3'd2, 1'b0, 32'h0050_0800, 1'b0, 1'b1, 4'd7},
    {3'd2, 1'b0, 32'h0050_1000, 1'b1, 1'b1, 4'd6},
    {3'd1, 1'b0, 32'h0060_0000, 1'b0, 1'b1, 4'd8},
    {3'd1, 1'b0, 32'h0070_0000, 1'b0, 1'b1, 4'd0},
    {3'd3, 1'b1, 32'h8000_0000, 1'b1, 1'b0, 4'd0},
    {3'd1, 1'b0, 32'h9000_0010, 1'b0, 1'b1, 4'd10},
    {3'd2, 1'b1, 32'h9000_0FFF, 1'b1, 1'b1, 4'd10},
    {3'd2, 1'b1, 32'h9000_1000, 1'b1, 1'b0, 4'd0},
    {3'd0, 1'b1, 32'h0021_0000, 1'b0, 1'b1, 4'd0},
    {3'd6, 1'b0, 32'h0020_0000, 1'b0, 1'b1, 4'd2}
  };
  string tags [NV] = '{"R6", "R6", "R6", "R8", "R6", "R8", "R5", "R3", "R3",
                       "R7", "R7", "R6", "R9", "R4", "R5", "R3", "R3", "R5", "R8"};

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic set_region(input logic [2:0] who, input logic [3:0] idx, input logic en,
                            input logic [31:0] base, input logic [5:0] lsz,
                            input logic [1:0] attr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ctx = who; cfg_kind = 1'b0; cfg_idx = idx;
    cfg_en = en; cfg_base = base; cfg_lsz = lsz; cfg_attr = attr;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_mask(input logic [2:0] who, input logic [3:0] idx,
                          input logic [15:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ctx = who; cfg_kind = 1'b1; cfg_idx = idx; cfg_mask = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic [2:0] c, input logic w, input logic [31:0] a);
    @(negedge clk);
    acc_valid = 1'b1; acc_ctx = c; acc_write = w; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "rsp_valid", 32'(rsp_valid), 0);
    chk("R1", "rsp_grant|fault", 32'(rsp_grant | rsp_fault), 0);
    chk("R1", "flt_addr", flt_addr, 0);
    access(3'd2, 1'b1, 32'h0020_0000);
    chk("R1", "grant before config", 32'(rsp_grant), 1);
    chk("R1", "hit before config", 32'(rsp_hit), 0);
    chk("R2", "valid after access", 32'(rsp_valid), 1);
    @(negedge clk);
    chk("R2", "idle valid", 32'(rsp_valid), 0);
    chk("R2", "idle grant|fault", 32'(rsp_grant | rsp_fault), 0);

    // region map
    set_region(0, 0,  1, 32'h0000_0000, 31, 2'b00);
    set_region(0, 1,  1, 32'h0010_0000, 20, 2'b01);
    set_region(0, 2,  1, 32'h0020_0000, 16, 2'b10);
    set_region(0, 3,  1, 32'h0030_0000, 16, 2'b10);
    set_region(0, 4,  1, 32'h0030_0000, 16, 2'b01);
    set_region(0, 5,  1, 32'h0040_0000, 2,  2'b10);
    set_region(0, 6,  1, 32'h0050_0000, 16, 2'b10);
    set_region(0, 7,  1, 32'h0050_0000, 12, 2'b00);
    set_region(0, 8,  1, 32'h0060_0000, 12, 2'b11);
    set_region(0, 9,  0, 32'h0070_0000, 12, 2'b10);
    set_region(0, 10, 1, 32'h9000_0000, 12, 2'b10);
    set_mask(0, 0, 16'h0006);
    set_mask(0, 1, 16'h0326);
    set_mask(0, 2, 16'h04C6);
    set_mask(0, 3, 16'h000E);
    set_mask(0, 4, 16'h0016);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      access(v[41:39], v[38], v[37:6]);
      chk(tags[i], $sformatf("vec%0d valid", i), 32'(rsp_valid), 1);
      chk(tags[i], $sformatf("vec%0d grant", i), 32'(rsp_grant), 32'(v[5]));
      chk(tags[i], $sformatf("vec%0d fault", i), 32'(rsp_fault), 32'(!v[5]));
      chk(tags[i], $sformatf("vec%0d hit", i), 32'(rsp_hit), 32'(v[4]));
      chk(tags[i], $sformatf("vec%0d region", i), 32'(rsp_region), 32'(v[3:0]));
      if (!v[5]) begin
        chk("R11", $sformatf("vec%0d flt_ctx", i), 32'(flt_ctx), 32'(v[41:39]));
        chk("R11", $sformatf("vec%0d flt_addr", i), flt_addr, v[37:6]);
      end
    end

    // R11: fault record kept across a grant
    access(3'd1, 1'b0, 32'h0060_0000);
    access(3'd2, 1'b0, 32'h0020_0000);
    chk("R11", "grant after fault", 32'(rsp_grant), 1);
    chk("R11", "flt_ctx held", 32'(flt_ctx), 1);
    chk("R11", "flt_addr held", flt_addr, 32'h0060_0000);

    // R10: non-master writes are dropped
    set_region(3'd2, 4'd2, 1, 32'h0020_0000, 16, 2'b00);
    set_mask(3'd1, 4'd1, 16'h0000);
    access(3'd2, 1'b1, 32'h0020_1000);
    chk("R10", "region kept", 32'(rsp_grant), 1);
    access(3'd1, 1'b0, 32'h0010_0040);
    chk("R10", "mask kept grant", 32'(rsp_grant), 1);
    chk("R10", "mask kept region", 32'(rsp_region), 1);

    // R12: same-cycle write and access
    @(negedge clk);
    cfg_we = 1'b1; cfg_ctx = 0; cfg_kind = 1'b0; cfg_idx = 4'd2;
    cfg_en = 1'b1; cfg_base = 32'h0020_0000; cfg_lsz = 16; cfg_attr = 2'b00;
    acc_valid = 1'b1; acc_ctx = 3'd2; acc_write = 1'b1; acc_addr = 32'h0020_0000;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R12", "old config used", 32'(rsp_grant), 1);
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R12", "new config next cycle", 32'(rsp_fault), 1);
    chk("R12", "new config region", 32'(rsp_region), 2);

    // R3: size field at or beyond the address width covers everything
    set_region(0, 15, 1, 32'h0000_0000, 32, 2'b10);
    set_mask(0, 3, 16'h800E);
    access(3'd3, 1'b0, 32'hF000_0000);
    chk("R3", "whole space grant", 32'(rsp_grant), 1);
    chk("R3", "whole space region", 32'(rsp_region), 15);
    access(3'd1, 1'b0, 32'hF000_0000);
    chk("R3", "whole space other ctx", 32'(rsp_fault), 1);
    chk("R5", "whole space other region", 32'(rsp_region), 15);

    finish_run();
  end
endmodule